// File: doc/BRIEF.md
# Page-Buffered EEPROM Write Engine

This block stands between a two-wire serial slave controller and a byte-wide nonvolatile memory array. While a write transaction is on the bus, the controller passes it decoded events as single-cycle pulses: a start, the address byte, each data byte and the end of the transaction. The engine keeps the target page and a small page buffer holding up to one page of bytes. Each byte goes to the buffer slot named by the low bits of a running pointer, and that pointer wraps inside the page.

The array changes only when the controller reports a stop that fell in the slot right after an acknowledged data byte (a commit). Any other ending, such as an abort or a new start, throws the buffer away. After a commit the engine runs a self-timed write window of a programmable number of clocks. Throughout the window it holds a busy flag, which the controller uses to withhold acknowledges, and it ignores every controller event. During the window it replays the filled buffer slots to the array, one per clock. A write-control input sampled from the start through the address byte can lock the whole transaction out.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, busy_o, data_ack_o and mem_we_o are all 0.
- R2: With a page of 16 bytes, the address byte's low 4 bits set the first buffer slot and the upper bits set the page. Each accepted data byte moves the slot up by one and wraps from 15 to 0 inside the same page, so the byte is written to {page, slot}.
- R3: The array is written only after commit_i. An abort_i pulse or a new start_i pulse discards every buffered byte. If commit_i and abort_i arrive in the same cycle, abort wins, busy_o stays 0 and nothing is written.
- R4: If wp_i is 1 in any cycle from the start_i pulse through the addr_load_i pulse, data_ack_o stays 0, data bytes are not buffered and a later commit writes nothing. wp_i going high after the address byte has no effect.
- R5: A commit raises busy_o in the next cycle and holds it for exactly WRITE_CYCLES cycles. While busy_o is 1, start_i, addr_load_i, data_load_i, commit_i and abort_i are ignored.
- R6: During the busy window, each buffer slot filled in the transaction is written to the array exactly once, one write per clock, in ascending slot order from slot 0. Slots that were not filled are not written.
- R7: A data byte that lands on a slot already filled in the same transaction replaces the earlier byte, so 17 bytes make 16 writes and the first slot holds the 17th byte.
- R8: A commit with no buffered byte starts no busy window.
- R9: data_ack_o is 1 only after an address byte in a transaction that is unprotected and when busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start condition seen (pulse) |
| wp_i | input | 1 | Write-control level, 1 = protect |
| addr_load_i | input | 1 | Address byte received (pulse) |
| addr_i | input | ADDR_W | Byte address from the address byte |
| data_load_i | input | 1 | Data byte received (pulse) |
| data_i | input | 8 | Data byte value |
| commit_i | input | 1 | Stop right after an acknowledged data byte (pulse) |
| abort_i | input | 1 | Stop in any other slot or repeated start (pulse) |
| busy_o | output | 1 | Self-timed write window in progress |
| data_ack_o | output | 1 | Data bytes would be acknowledged |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
Two things can fall in the same cycle. A commit can meet an abort. Controller events can also arrive while the write window is running. The bench drives commit_i and abort_i in one cycle and checks that busy_o stays 0 and the array model keeps FFh at the target address. In another test it sends a full transaction with start, address, data and commit inside a busy window. It then checks that the window ran exactly WRITE_CYCLES cycles, that only the first byte reached the array and that data_ack_o stayed 0.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_BURN = 1'b1
    } tmr_state_e;

    // controller events after gating by the busy window
    typedef struct packed {
        logic start;
        logic addr;
        logic data;
        logic commit;
        logic abort;
    } pw_evt_t;

endpackage

// File: rtl/pw_guard.sv
module pw_guard (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic start_i,
    input  logic addr_i,
    input  logic wp_i,
    output logic armed_o,
    output logic blocked_o
);
    logic win_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            win_q     <= 1'b0;
            armed_o   <= 1'b0;
            blocked_o <= 1'b0;
        end else if (start_i) begin
            win_q     <= 1'b1;
            armed_o   <= 1'b0;
            blocked_o <= wp_i;
        end else if (win_q) begin
            if (wp_i) blocked_o <= 1'b1;
            if (addr_i) begin
                win_q   <= 1'b0;
                armed_o <= 1'b1;
            end
        end
    end

    // R4
    blocked_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (blocked_o && !clr_i && !start_i) |=> blocked_o);

endmodule

// File: rtl/pw_page_buf.sv
module pw_page_buf
    import eeprom_pw_pkg::*;
#(
    parameter int unsigned PAGE_BYTES = 16,
    parameter int unsigned ADDR_W     = 11,
    localparam int unsigned SW        = $clog2(PAGE_BYTES),
    localparam int unsigned PW        = ADDR_W - SW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr_i,
    input  logic                  set_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  load_i,
    input  logic                  en_i,
    input  byte_t                 din_i,
    input  logic [SW-1:0]         rd_slot_i,
    output byte_t                 rd_data_o,
    output logic [PAGE_BYTES-1:0] valid_o,
    output logic [PW-1:0]         page_o
);
    byte_t         mem_q [PAGE_BYTES];
    logic [SW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            valid_o <= '0;
        end else if (load_i && en_i) begin
            valid_o[ptr_q] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            page_o <= '0;
        end else if (set_i) begin
            ptr_q  <= addr_i[SW-1:0];
            page_o <= addr_i[ADDR_W-1:SW];
        end else if (load_i && en_i) begin
            ptr_q  <= ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (load_i && en_i && !set_i) mem_q[ptr_q] <= din_i;
    end

    assign rd_data_o = mem_q[rd_slot_i];

    // R4
    blocked_load_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && !en_i && !clr_i) |=> $stable(valid_o));

endmodule

// File: rtl/pw_timer.sv
module pw_timer
    import eeprom_pw_pkg::*;
#(
    parameter int unsigned WRITE_CYCLES = 40,
    parameter int unsigned PAGE_BYTES   = 16,
    localparam int unsigned CW          = $clog2(WRITE_CYCLES),
    localparam int unsigned SW          = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          slot_live_o,
    output logic [SW-1:0] slot_o
);
    tmr_state_e    st_q;
    logic [CW-1:0] cnt_q;
    logic          last;

    assign last = (cnt_q == CW'(WRITE_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= TMR_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                TMR_IDLE: if (go_i) begin
                    st_q  <= TMR_BURN;
                    cnt_q <= '0;
                end
                TMR_BURN: if (last) st_q <= TMR_IDLE;
                          else      cnt_q <= cnt_q + 1'b1;
                default:  st_q <= TMR_IDLE;
            endcase
        end
    end

    assign busy_o      = (st_q == TMR_BURN);
    assign done_o      = busy_o && last;
    assign slot_live_o = busy_o && (int'(cnt_q) < PAGE_BYTES);
    assign slot_o      = cnt_q[SW-1:0];

    // R5
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(go_i));

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import eeprom_pw_pkg::*;
#(
    parameter int unsigned ADDR_W       = 11,
    parameter int unsigned PAGE_BYTES   = 16,
    parameter int unsigned WRITE_CYCLES = 40,
    localparam int unsigned SW          = $clog2(PAGE_BYTES),
    localparam int unsigned PW          = ADDR_W - SW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              wp_i,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              data_load_i,
    input  logic [7:0]        data_i,
    input  logic              commit_i,
    input  logic              abort_i,
    output logic              busy_o,
    output logic              data_ack_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o
);
    pw_evt_t               evt;
    logic                  armed, blocked, done, slot_live, go;
    logic [SW-1:0]         slot;
    logic [PAGE_BYTES-1:0] valid;
    logic [PW-1:0]         page;
    byte_t                 rd_data;

    // every controller event is dropped while the write window runs
    always_comb begin
        evt.start  = start_i     && !busy_o;
        evt.addr   = addr_load_i && !busy_o;
        evt.data   = data_load_i && !busy_o;
        evt.abort  = abort_i     && !busy_o;
        evt.commit = commit_i    && !busy_o && !abort_i && !start_i;
    end

    assign go = evt.commit && armed && !blocked && (|valid);

    pw_guard u_guard (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (evt.abort || done),
        .start_i   (evt.start),
        .addr_i    (evt.addr),
        .wp_i      (wp_i),
        .armed_o   (armed),
        .blocked_o (blocked)
    );

    pw_page_buf #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (evt.abort || evt.start || done),
        .set_i     (evt.addr),
        .addr_i    (addr_i),
        .load_i    (evt.data),
        .en_i      (armed && !blocked),
        .din_i     (data_i),
        .rd_slot_i (slot),
        .rd_data_o (rd_data),
        .valid_o   (valid),
        .page_o    (page)
    );

    pw_timer #(.WRITE_CYCLES(WRITE_CYCLES), .PAGE_BYTES(PAGE_BYTES)) u_tmr (
        .clk         (clk),
        .rst         (rst),
        .go_i        (go),
        .busy_o      (busy_o),
        .done_o      (done),
        .slot_live_o (slot_live),
        .slot_o      (slot)
    );

    assign data_ack_o  = armed && !blocked && !busy_o;
    assign mem_we_o    = slot_live && valid[slot];
    assign mem_addr_o  = {page, slot};
    assign mem_wdata_o = rd_data;

    // R6
    we_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> busy_o);

    // R9
    ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
        data_ack_o |-> !busy_o);

    // R3
    abort_nogo_chk: assert property (@(posedge clk) disable iff (rst)
        (abort_i && !busy_o) |=> !busy_o);

endmodule

// File: tb/test_eeprom_page_writer.sv
module test_eeprom_page_writer;
    localparam int AW = 11;
    localparam int WC = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 0, wp_i = 0, addr_load_i = 0, data_load_i = 0;
    logic commit_i = 0, abort_i = 0;
    logic [AW-1:0] addr_i = '0;
    logic [7:0] data_i = '0;
    logic busy_o, data_ack_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [7:0] mem_wdata_o;

    int total = 0, bad = 0, cyc = 0;
    int busy_cycles = 0, wcount = 0;
    logic [AW-1:0] wlog [32];
    logic [7:0] mem [2048];

    always #10 clk = ~clk;

    eeprom_page_writer #(.ADDR_W(AW), .PAGE_BYTES(16), .WRITE_CYCLES(WC)) i_eeprom_page_writer (
        .clk(clk), .rst(rst), .start_i(start_i), .wp_i(wp_i),
        .addr_load_i(addr_load_i), .addr_i(addr_i),
        .data_load_i(data_load_i), .data_i(data_i),
        .commit_i(commit_i), .abort_i(abort_i),
        .busy_o(busy_o), .data_ack_o(data_ack_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o));

    initial for (int i = 0; i < 2048; i++) mem[i] = 8'hFF;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && busy_o) busy_cycles <= busy_cycles + 1;
        if (!rst && mem_we_o) begin
            mem[mem_addr_o] <= mem_wdata_o;
            if (wcount < 32) wlog[wcount] <= mem_addr_o;
            wcount <= wcount + 1;
        end
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
            bad = bad + 1;
            total = total + 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start(input logic wp);
        @(negedge clk); wp_i = wp; start_i = 1;
        @(negedge clk); start_i = 0;
    endtask
    task automatic pulse_addr(input logic [AW-1:0] a);
        @(negedge clk); addr_i = a; addr_load_i = 1;
        @(negedge clk); addr_load_i = 0;
    endtask
    task automatic pulse_data(input logic [7:0] d);
        @(negedge clk); data_i = d; data_load_i = 1;
        @(negedge clk); data_load_i = 0;
    endtask
    task automatic pulse_commit(input logic with_abort);
        @(negedge clk); commit_i = 1; abort_i = with_abort;
        @(negedge clk); commit_i = 0; abort_i = 0;
    endtask
    task automatic pulse_abort();
        @(negedge clk); abort_i = 1;
        @(negedge clk); abort_i = 0;
    endtask
    task automatic clear_log();
        @(negedge clk); busy_cycles = 0; wcount = 0;
    endtask
    task automatic wait_idle();
        for (int k = 0; k < 4 * WC && busy_o; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(busy_o == 0, "R1 busy", busy_o, 0);
        check(data_ack_o == 0, "R1 ack", data_ack_o, 0);
        check(mem_we_o == 0 && wcount == 0, "R1 we", wcount, 0);
    endtask

    task automatic t_byte_write();
        clear_log();
        pulse_start(0);
        check(data_ack_o == 0, "R9 ack before address", data_ack_o, 0);
        pulse_addr(11'h123);
        check(data_ack_o == 1, "R9 ack after address", data_ack_o, 1);
        pulse_data(8'hA5);
        pulse_commit(0);
        check(busy_o == 1, "R5 busy after commit", busy_o, 1);
        wait_idle();
        check(busy_cycles == WC, "R5 busy length", busy_cycles, WC);
        check(mem[11'h123] == 8'hA5, "R6 byte written", mem[11'h123], 8'hA5);
        check(wcount == 1, "R6 write count", wcount, 1);
    endtask

    task automatic t_wrap();
        clear_log();
        pulse_start(0);
        pulse_addr(11'h1FE);
        pulse_data(8'h11); pulse_data(8'h22); pulse_data(8'h33);
        pulse_commit(0);
        wait_idle();
        check(mem[11'h1FE] == 8'h11, "R2 slot 14", mem[11'h1FE], 8'h11);
        check(mem[11'h1FF] == 8'h22, "R2 slot 15", mem[11'h1FF], 8'h22);
        check(mem[11'h1F0] == 8'h33, "R2 wrap to slot 0", mem[11'h1F0], 8'h33);
        check(mem[11'h1F1] == 8'hFF && mem[11'h200] == 8'hFF, "R6 unfilled untouched", mem[11'h1F1], 8'hFF);
        check(wcount == 3, "R6 write count", wcount, 3);
        check(wlog[0] == 11'h1F0 && wlog[1] == 11'h1FE && wlog[2] == 11'h1FF,
              "R6 ascending slot order", wlog[0], 11'h1F0);
    endtask

    task automatic t_overwrite();
        clear_log();
        pulse_start(0);
        pulse_addr(11'h040);
        for (int i = 0; i < 17; i++) pulse_data(8'h80 + 8'(i));
        pulse_commit(0);
        wait_idle();
        check(mem[11'h040] == 8'h90, "R7 slot replaced", mem[11'h040], 8'h90);
        check(mem[11'h04F] == 8'h8F, "R7 last slot", mem[11'h04F], 8'h8F);
        check(wcount == 16, "R7 sixteen writes", wcount, 16);
    endtask

    task automatic t_abort();
        clear_log();
        pulse_start(0);
        pulse_addr(11'h300);
        pulse_data(8'h5A);
        pulse_abort();
        pulse_commit(0);
        check(busy_o == 0, "R3 abort then commit", busy_o, 0);
        pulse_start(0);
        pulse_addr(11'h310);
        pulse_data(8'h6B);
        pulse_start(0);
        pulse_addr(11'h320);
        pulse_commit(0);
        check(busy_o == 0, "R8 commit with empty buffer", busy_o, 0);
        wait_idle();
        check(mem[11'h300] == 8'hFF && mem[11'h310] == 8'hFF, "R3 discarded", mem[11'h310], 8'hFF);
        check(wcount == 0, "R3 no writes", wcount, 0);
    endtask

    task automatic t_same_cycle();
        clear_log();
        pulse_start(0);
        pulse_addr(11'h500);
        pulse_data(8'h42);
        pulse_commit(1);
        check(busy_o == 0, "R3 abort wins over commit", busy_o, 0);
        wait_idle();
        check(mem[11'h500] == 8'hFF && wcount == 0, "R3 abort wins no write", mem[11'h500], 8'hFF);
    endtask

    task automatic t_protect();
        clear_log();
        pulse_start(1);
        wp_i = 0;
        pulse_addr(11'h600);
        check(data_ack_o == 0, "R4 wp at start blocks ack", data_ack_o, 0);
        pulse_data(8'h01);
        pulse_commit(0);
        check(busy_o == 0, "R4 protected commit", busy_o, 0);
        pulse_start(0);
        @(negedge clk); wp_i = 1;
        @(negedge clk); wp_i = 0;
        pulse_addr(11'h610);
        check(data_ack_o == 0, "R4 wp mid window blocks ack", data_ack_o, 0);
        pulse_data(8'h02);
        pulse_commit(0);
        wait_idle();
        check(mem[11'h600] == 8'hFF && mem[11'h610] == 8'hFF && wcount == 0,
              "R4 array untouched", mem[11'h610], 8'hFF);
        pulse_start(0);
        pulse_addr(11'h620);
        wp_i = 1;
        @(negedge clk);
        check(data_ack_o == 1, "R4 late wp ignored ack", data_ack_o, 1);
        pulse_data(8'h03);
        pulse_commit(0);
        wp_i = 0;
        wait_idle();
        check(mem[11'h620] == 8'h03, "R4 late wp write done", mem[11'h620], 8'h03);
    endtask

    task automatic t_busy_ignore();
        clear_log();
        pulse_start(0);
        pulse_addr(11'h400);
        pulse_data(8'h77);
        pulse_commit(0);
        pulse_start(0);
        pulse_addr(11'h410);
        check(data_ack_o == 0, "R9 no ack while busy", data_ack_o, 0);
        pulse_data(8'h99);
        pulse_commit(0);
        pulse_abort();
        wait_idle();
        check(busy_cycles == WC, "R5 window not extended", busy_cycles, WC);
        check(mem[11'h400] == 8'h77 && mem[11'h410] == 8'hFF, "R5 busy events ignored", mem[11'h410], 8'hFF);
        check(wcount == 1, "R5 one write", wcount, 1);
        pulse_commit(0);
        check(busy_o == 0, "R8 no second window", busy_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_byte_write();
        t_wrap();
        t_overwrite();
        t_abort();
        t_same_cycle();
        t_protect();
        t_busy_ignore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule